// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block collects level-sensitive interrupt lines from up to 128 peripherals and presents one interrupt request to a processor. The sources are grouped into banks of 32. Each bank has a mask word and a pending word. The mask word can only be changed through two write-one addresses: one clears mask bits and one sets them. The pending word shows the sources that are both asserted and unmasked.

When no interrupt is latched and at least one source is pending, the controller picks a winner. The winner is the source with the lowest priority value in its level register, and a tie goes to the lowest source index. The controller latches the winner's number, which software reads from the sorted-interrupt register, and holds the request line high. Software ends the interrupt by writing the acknowledge bit. This write is accepted even when nothing is latched. If the latched source stops pending first, the latch clears by itself. The register file also has a revision word, an autoidle bit, three plain storage registers and a soft-reset handshake.

The register port is a single-cycle write strobe with a combinational read. The bank count follows from the `NUM_SRC` parameter.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After hardware reset, every mask word (0x84 + 0x20·bank) reads 0xFFFFFFFF, `irq_o` is low, the status word 0x14 reads 1, the config word 0x10 reads 0, the sorted-interrupt word 0x40 reads 0 and every pending word reads 0.
- R2: A write to 0x88 + 0x20·bank clears the mask bits where the write data has ones. A write to 0x8C + 0x20·bank sets them. Zero data bits leave the mask unchanged, and other banks are not affected.
- R3: The pending word at 0x98 + 0x20·bank equals the source lines of that bank ANDed with the inverse of its mask.
- R4: When no interrupt is latched, the pending source with the smallest priority value (bits 7:2 of its level register) is latched. Ties go to the lowest index. The sorted-interrupt word 0x40 returns the latched number in bits 6:0, and returns 0 when nothing is latched.
- R5: `irq_o` rises one cycle after a source becomes pending while no interrupt is latched. The latched number stays the same until it is acknowledged or its source stops pending, even when a higher-priority source arrives.
- R6: Writing a 1 to bit 0 of 0x48 drops `irq_o` on the next cycle, and a new winner is latched one cycle later. The same write with nothing latched changes no register.
- R7: If the latched source stops pending, by deassertion or by masking, the latch clears on the next clock edge and `irq_o` goes low.
- R8: Writing bit 1 of 0x10 starts a soft reset. Status bit 0 at 0x14 reads 0 for `SRST_CYCLES` cycles and then reads 1. After that, every mask, level and storage register holds its reset value and `irq_o` is low.
- R9: Bit 0 of 0x10 (autoidle), the 32-bit words at 0x4C, 0x50 and 0x68, and the 8-bit level field at 0x100 + 4·index read back the values last written.
- R10: The word at 0x00 returns `REV_MAJOR` in bits 7:4 and `REV_MINOR` in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Level interrupt lines, one per source |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_o | output | 1 | Interrupt request, high while a winner is latched |

## Verification
The checker tests the following on every cycle:
- The write-one rules for mask set and mask clear.
- That a pending source is latched on the next edge when nothing is held.
- That the latched number holds while its source stays pending and no acknowledge arrives.
- That an acknowledge or a vanished source drops the request.
- That a soft reset clears the done bit and leaves every mask set when it ends.

Some behaviour needs the bench's scenarios:
- Which source wins, for priority against index and for equal priorities.
- The pending words read through the port.
- The storage and revision registers.
- That an acknowledge with nothing latched leaves the state unchanged.

// File: rtl/bic_pkg.sv
package bic_pkg;
   localparam int ADDR_W      = 12;
   localparam int DATA_W      = 32;
   localparam int BANK_W      = 32;
   localparam int LVL_W       = 8;
   localparam int PRIO_LSB    = 2;
   localparam int PRIO_W      = 6;
   localparam int NUM_W       = 7;
   localparam int MAX_SRC     = 1 << NUM_W;
   localparam int BANK_STRIDE = 'h20;

   localparam logic [ADDR_W-1:0] A_REV      = 12'h000;
   localparam logic [ADDR_W-1:0] A_CFG      = 12'h010;
   localparam logic [ADDR_W-1:0] A_STAT     = 12'h014;
   localparam logic [ADDR_W-1:0] A_SIR      = 12'h040;
   localparam logic [ADDR_W-1:0] A_CTRL     = 12'h048;
   localparam logic [ADDR_W-1:0] A_PROT     = 12'h04C;
   localparam logic [ADDR_W-1:0] A_IDLE     = 12'h050;
   localparam logic [ADDR_W-1:0] A_THR      = 12'h068;
   localparam logic [ADDR_W-1:0] A_MASK0    = 12'h084;
   localparam logic [ADDR_W-1:0] A_UNMASK0  = 12'h088;
   localparam logic [ADDR_W-1:0] A_SETMASK0 = 12'h08C;
   localparam logic [ADDR_W-1:0] A_PEND0    = 12'h098;
   localparam logic [ADDR_W-1:0] A_LVL0     = 12'h100;
endpackage

// File: rtl/bic_mask_bank.sv
module bic_mask_bank #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_all,
   input  logic         unmask_we,
   input  logic         mask_we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] src,
   output logic [W-1:0] mask,
   output logic [W-1:0] pend
);
   // every source starts masked; only write-one strobes move bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mask <= '1;
      else if (clr_all)    mask <= '1;
      else if (unmask_we)  mask <= mask & ~wdata;
      else if (mask_we)    mask <= mask | wdata;
   end

   assign pend = src & ~mask;
endmodule

// File: rtl/bic_prio_sel.sv
module bic_prio_sel #(
   parameter int N  = 96,
   parameter int PW = 6,
   parameter int IW = 7
) (
   input  logic [N-1:0]         req,
   input  logic [N-1:0][PW-1:0] prio,
   output logic                 found,
   output logic [IW-1:0]        idx
);
   logic [PW-1:0] best;

   // strict less-than keeps the lowest index on equal priority
   always_comb begin
      found = 1'b0;
      idx   = '0;
      best  = '1;
      for (int i = 0; i < N; i++) begin
         if (req[i] && (!found || (prio[i] < best))) begin
            found = 1'b1;
            idx   = IW'(i);
            best  = prio[i];
         end
      end
   end
endmodule

// File: rtl/bic_srst_seq.sv
module bic_srst_seq #(
   parameter int CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

   logic busy_q, done_q;

   if (CYCLES < 1) begin : g_bad_cycles
      $error("bic_srst_seq: CYCLES must be at least 1");
   end

   if (CYCLES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end else if (busy_q) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end else if (start) begin
            busy_q <= 1'b1;
            done_q <= 1'b0;
         end
      end
   end else begin : g_cnt
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            cnt    <= '0;
         end else if (busy_q) begin
            if (cnt == CW'(CYCLES - 1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               cnt    <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else if (start) begin
            busy_q <= 1'b1;
            done_q <= 1'b0;
            cnt    <= '0;
         end
      end
   end

   assign busy = busy_q;
   assign done = done_q;
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
   import bic_pkg::*;
#(
   parameter int NUM_SRC     = 96,
   parameter int SRST_CYCLES = 4,
   parameter int REV_MAJOR   = 2,
   parameter int REV_MINOR   = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq_o
);
   localparam int NUM_BANKS = NUM_SRC / BANK_W;

   if ((NUM_SRC % BANK_W) != 0 || NUM_SRC < BANK_W || NUM_SRC > MAX_SRC) begin : g_bad_src
      $error("banked_irq_ctrl: NUM_SRC must be a multiple of 32 between 32 and 128");
   end
   if (REV_MAJOR < 0 || REV_MAJOR > 15 || REV_MINOR < 0 || REV_MINOR > 15) begin : g_bad_rev
      $error("banked_irq_ctrl: revision fields are 4 bits each");
   end

   // soft reset sequencing
   logic srst_busy, srst_done, srst_start, wr_ok;
   assign wr_ok      = bus_wr && !srst_busy;
   assign srst_start = wr_ok && (bus_addr == A_CFG) && bus_wdata[1];

   bic_srst_seq #(.CYCLES(SRST_CYCLES)) u_srst (
      .clk   (clk),
      .rst_n (rst_n),
      .start (srst_start),
      .busy  (srst_busy),
      .done  (srst_done)
   );

   // plain storage registers
   logic              cfg_autoidle;
   logic [DATA_W-1:0] prot_q, idle_q, thr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_autoidle <= 1'b0;
         prot_q       <= '0;
         idle_q       <= '0;
         thr_q        <= '0;
      end else if (srst_busy) begin
         cfg_autoidle <= 1'b0;
         prot_q       <= '0;
         idle_q       <= '0;
         thr_q        <= '0;
      end else if (bus_wr) begin
         if (bus_addr == A_CFG)  cfg_autoidle <= bus_wdata[0];
         if (bus_addr == A_PROT) prot_q       <= bus_wdata;
         if (bus_addr == A_IDLE) idle_q       <= bus_wdata;
         if (bus_addr == A_THR)  thr_q        <= bus_wdata;
      end
   end

   // per-source level registers
   logic [NUM_SRC-1:0][LVL_W-1:0]  lvl_q;
   logic [NUM_SRC-1:0][PRIO_W-1:0] prio_vec;
   logic [ADDR_W-1:0]              lvl_off;
   logic [NUM_W-1:0]               lvl_sel;
   logic                           lvl_hit;

   assign lvl_off = bus_addr - A_LVL0;
   assign lvl_sel = lvl_off[NUM_W+1:2];
   assign lvl_hit = (bus_addr >= A_LVL0) && (lvl_off[1:0] == 2'b00) &&
                    (lvl_off[ADDR_W-1:2] < (ADDR_W-2)'(NUM_SRC));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                lvl_q <= '0;
      else if (srst_busy)        lvl_q <= '0;
      else if (wr_ok && lvl_hit) lvl_q[lvl_sel] <= bus_wdata[LVL_W-1:0];
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_prio
      assign prio_vec[s] = lvl_q[s][PRIO_LSB +: PRIO_W];
   end

   // mask banks
   logic [NUM_SRC-1:0] mask_all, pend_all;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic unmask_hit, mask_hit;
      assign unmask_hit = wr_ok && (bus_addr == A_UNMASK0 + ADDR_W'(b * BANK_STRIDE));
      assign mask_hit   = wr_ok && (bus_addr == A_SETMASK0 + ADDR_W'(b * BANK_STRIDE));

      bic_mask_bank #(.W(BANK_W)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .clr_all   (srst_busy),
         .unmask_we (unmask_hit),
         .mask_we   (mask_hit),
         .wdata     (bus_wdata),
         .src       (src_i[b*BANK_W +: BANK_W]),
         .mask      (mask_all[b*BANK_W +: BANK_W]),
         .pend      (pend_all[b*BANK_W +: BANK_W])
      );
   end

   // winner selection and latch
   logic             win_found;
   logic [NUM_W-1:0] win_idx;

   bic_prio_sel #(.N(NUM_SRC), .PW(PRIO_W), .IW(NUM_W)) u_sel (
      .req   (pend_all),
      .prio  (prio_vec),
      .found (win_found),
      .idx   (win_idx)
   );

   logic             ack;
   logic             act_valid;
   logic [NUM_W-1:0] act_idx;

   assign ack = wr_ok && (bus_addr == A_CTRL) && bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_valid <= 1'b0;
         act_idx   <= '0;
      end else if (srst_busy) begin
         act_valid <= 1'b0;
         act_idx   <= '0;
      end else if (act_valid) begin
         if (ack || !pend_all[act_idx]) act_valid <= 1'b0;
      end else if (win_found) begin
         act_valid <= 1'b1;
         act_idx   <= win_idx;
      end
   end

   assign irq_o = act_valid;

   // read mux
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_REV:   bus_rdata = {24'b0, 4'(REV_MAJOR), 4'(REV_MINOR)};
         A_CFG:   bus_rdata = {31'b0, cfg_autoidle};
         A_STAT:  bus_rdata = {31'b0, srst_done};
         A_SIR:   bus_rdata = {25'b0, act_valid ? act_idx : {NUM_W{1'b0}}};
         A_PROT:  bus_rdata = prot_q;
         A_IDLE:  bus_rdata = idle_q;
         A_THR:   bus_rdata = thr_q;
         default: bus_rdata = '0;
      endcase
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bus_addr == A_MASK0 + ADDR_W'(b * BANK_STRIDE)) bus_rdata = mask_all[b*BANK_W +: BANK_W];
         if (bus_addr == A_PEND0 + ADDR_W'(b * BANK_STRIDE)) bus_rdata = pend_all[b*BANK_W +: BANK_W];
      end
      if (lvl_hit) bus_rdata = {24'b0, lvl_q[lvl_sel]};
   end
endmodule

// File: rtl/bic_checker.sv
module bic_checker
   import bic_pkg::*;
#(
   parameter int NUM_SRC = 96
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic               irq_o,
   input logic               act_valid,
   input logic [NUM_W-1:0]   act_idx,
   input logic [NUM_SRC-1:0] pend_all,
   input logic [NUM_SRC-1:0] mask_all,
   input logic               srst_busy,
   input logic               srst_done
);
   logic wr_live, ack_wr;
   assign wr_live = bus_wr && !srst_busy;
   assign ack_wr  = wr_live && (bus_addr == A_CTRL) && bus_wdata[0];

   assert_unmask_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_live && bus_addr == A_UNMASK0) |=> ((mask_all[31:0] & $past(bus_wdata)) == 32'b0));

   assert_setmask_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_live && bus_addr == A_SETMASK0) |=> ((mask_all[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

   assert_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_valid && (|pend_all) && !srst_busy) |=> irq_o);

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (act_valid && pend_all[act_idx] && !srst_busy && !ack_wr) |=> (irq_o && $stable(act_idx)));

   assert_ack_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && ack_wr) |=> !irq_o);

   assert_vanish_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (act_valid && !pend_all[act_idx]) |=> !irq_o);

   assert_srst_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_live && bus_addr == A_CFG && bus_wdata[1]) |=> !srst_done);

   assert_srst_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      srst_busy |=> !irq_o);

   assert_srst_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(srst_busy) |-> (&mask_all));
endmodule

bind banked_irq_ctrl bic_checker #(.NUM_SRC(NUM_SRC)) u_bic_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq_o     (irq_o),
   .act_valid (act_valid),
   .act_idx   (act_idx),
   .pend_all  (pend_all),
   .mask_all  (mask_all),
   .srst_busy (srst_busy),
   .srst_done (srst_done)
);

// File: tb/banked_irq_ctrl_tb_top.sv
module banked_irq_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NSRC       = 96;
   localparam int SRST       = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] src_i = '0;
   logic            bus_wr = 1'b0;
   logic [11:0]     bus_addr = '0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic            irq_o;

   int checks = 0;
   int failures = 0;
   bit mon_req = 1'b0;
   bit done_flag = 1'b0;

   typedef struct {
      bit          is_irq;
      logic [11:0] addr;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   banked_irq_ctrl #(.NUM_SRC(NSRC), .SRST_CYCLES(SRST), .REV_MAJOR(2), .REV_MINOR(1)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src_i),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o)
   );

   // monitor: pops expected items and compares mid-cycle
   always @(negedge clk) begin
      if (mon_req && sb_q.size() > 0) begin
         item_t it;
         logic [31:0] got;
         it = sb_q.pop_front();
         got = it.is_irq ? {31'b0, irq_o} : bus_rdata;
         checks++;
         if (got !== it.exp) begin
            failures++;
            $display("FAIL %s addr=0x%03h actual=0x%08h expected=0x%08h",
                     it.tag, it.addr, got, it.exp);
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic expect_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
      item_t it;
      it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      bus_addr = a; mon_req = 1'b1;
      tick();
      mon_req = 1'b0;
   endtask

   task automatic expect_irq(input logic e, input string tag);
      item_t it;
      it.is_irq = 1'b1; it.addr = '0; it.exp = {31'b0, e}; it.tag = tag;
      sb_q.push_back(it);
      mon_req = 1'b1;
      tick();
      mon_req = 1'b0;
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done_flag) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired before the scenario ended");
         report();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();

      // R1 reset state
      expect_rd(12'h084, 32'hFFFF_FFFF, "R1 mask0");
      expect_rd(12'h0A4, 32'hFFFF_FFFF, "R1 mask1");
      expect_rd(12'h0C4, 32'hFFFF_FFFF, "R1 mask2");
      expect_irq(1'b0, "R1 irq");
      expect_rd(12'h014, 32'h1, "R1 status");
      expect_rd(12'h010, 32'h0, "R1 config");
      expect_rd(12'h040, 32'h0, "R1 sir");
      expect_rd(12'h098, 32'h0, "R1 pend0");
      // R10 revision
      expect_rd(12'h000, 32'h21, "R10 revision");

      // R9 storage registers
      bus_write(12'h04C, 32'h5A5A_0001);
      bus_write(12'h050, 32'h0000_0003);
      bus_write(12'h068, 32'h0000_00FF);
      bus_write(12'h010, 32'h0000_0001);
      bus_write(12'h114, 32'h0000_00AC);
      bus_write(12'h118, 32'h0000_01AC);
      expect_rd(12'h04C, 32'h5A5A_0001, "R9 protection");
      expect_rd(12'h050, 32'h3, "R9 idle");
      expect_rd(12'h068, 32'hFF, "R9 threshold");
      expect_rd(12'h010, 32'h1, "R9 autoidle");
      expect_rd(12'h114, 32'hAC, "R9 level5");
      expect_rd(12'h118, 32'hAC, "R9 level6 8-bit field");

      // R2 write-one mask semantics
      bus_write(12'h088, 32'h0000_00F0);
      expect_rd(12'h084, 32'hFFFF_FF0F, "R2 clear");
      bus_write(12'h08C, 32'h0000_0010);
      expect_rd(12'h084, 32'hFFFF_FF1F, "R2 set");
      bus_write(12'h088, 32'h0);
      expect_rd(12'h084, 32'hFFFF_FF1F, "R2 zero write");
      bus_write(12'h0A8, 32'h0000_0001);
      expect_rd(12'h0A4, 32'hFFFF_FFFE, "R2 bank1 clear");
      expect_rd(12'h084, 32'hFFFF_FF1F, "R2 bank0 untouched");
      expect_irq(1'b0, "R2 nothing pending");

      // R3 pending words, R4 priority beats index
      src_i[4] = 1'b1; src_i[5] = 1'b1; src_i[32] = 1'b1; src_i[64] = 1'b1;
      expect_rd(12'h098, 32'h0000_0020, "R3 pend0");
      expect_rd(12'h0B8, 32'h0000_0001, "R3 pend1");
      expect_rd(12'h0D8, 32'h0, "R3 pend2");
      expect_irq(1'b1, "R5 irq raised");
      expect_rd(12'h040, 32'd32, "R4 priority over index");

      // R5 winner holds when a better source appears
      src_i[0] = 1'b1;
      bus_write(12'h088, 32'h0000_0001);
      expect_rd(12'h040, 32'd32, "R5 winner stable");
      expect_irq(1'b1, "R5 irq held");

      // R6 acknowledge and re-evaluation
      bus_write(12'h048, 32'h1);
      expect_irq(1'b0, "R6 irq drops after ack");
      expect_rd(12'h040, 32'd0, "R6 new winner source0");
      expect_irq(1'b1, "R6 irq relatched");

      // R7 latched source deasserts
      src_i[0] = 1'b0;
      tick();
      expect_irq(1'b0, "R7 deassert clears latch");
      expect_rd(12'h040, 32'd32, "R7 relatch after deassert");

      // R7 latched source masked
      bus_write(12'h0AC, 32'h0000_0001);
      tick();
      expect_irq(1'b0, "R7 mask clears latch");
      expect_rd(12'h040, 32'd5, "R7 next winner");

      // R4 equal priorities
      src_i = '0;
      tick();
      tick();
      bus_write(12'h208, 32'h10);
      bus_write(12'h218, 32'h10);
      bus_write(12'h210, 32'h14);
      src_i[66] = 1'b1; src_i[68] = 1'b1; src_i[70] = 1'b1;
      bus_write(12'h0C8, 32'h0000_0054);
      tick();
      expect_rd(12'h040, 32'd66, "R4 tie lowest index");
      src_i[66] = 1'b0;
      tick();
      tick();
      expect_rd(12'h040, 32'd70, "R4 priority among rest");

      // R6 acknowledge with nothing latched
      src_i = '0;
      tick();
      tick();
      expect_irq(1'b0, "R6 idle before ack");
      bus_write(12'h048, 32'h1);
      expect_irq(1'b0, "R6 idle ack irq");
      expect_rd(12'h040, 32'd0, "R6 idle ack sir");
      expect_rd(12'h084, 32'hFFFF_FF1E, "R6 idle ack mask0");
      expect_rd(12'h114, 32'hAC, "R6 idle ack level5");

      // R8 soft reset
      src_i[5] = 1'b1;
      tick();
      expect_irq(1'b1, "R8 irq before soft reset");
      bus_write(12'h010, 32'h0000_0002);
      expect_rd(12'h014, 32'h0, "R8 done low");
      repeat (SRST - 1) tick();
      expect_rd(12'h014, 32'h1, "R8 done high");
      expect_rd(12'h084, 32'hFFFF_FFFF, "R8 mask0 reset");
      expect_rd(12'h0C4, 32'hFFFF_FFFF, "R8 mask2 reset");
      expect_rd(12'h114, 32'h0, "R8 level reset");
      expect_rd(12'h04C, 32'h0, "R8 protection reset");
      expect_rd(12'h010, 32'h0, "R8 config reset");
      expect_irq(1'b0, "R8 irq low");
      expect_rd(12'h040, 32'h0, "R8 sir reset");

      tick();
      done_flag = 1'b1;
      report();
      $finish;
   end
endmodule